// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block watches a key matrix of six drive lines and five pulled-down sense lines, up to 30 keys. While idle it holds the drive lines at a fixed level pattern. A scan starts only when one of the sense lines reads 1. The scanner then pulses the drive lines one at a time through two full passes. It accepts the key result only when both passes hold the same bits. After a fixed delay from the start of the scan it latches the result and raises a read request for the host. The delay is counted in ticks of an external time base, one tick per oscillator period.

The host interface reads the captured bits and then pulses a read-done strobe. That pulse drops the request and starts a new scan at once, so a held key is reported again and a released matrix clears the key data. In sleep mode a two-bit code sets which drive lines idle high, and only a press on one of those lines can start a scan. The wake output tells the oscillator to run. One or two of the lowest drive lines can be handed over to the segment outputs. Those lines are then never driven, and their key bits read 0.

Top module: `key_matrix_scanner`

## Requirements
- R1: Synchronous reset clears all key data bits to 0, holds the read request low and returns the scanner to idle with the idle drive pattern on its drive lines.
- R2: While idle or waiting for a read, the drive lines take the idle pattern set by sleep_code_i, with bit 0 as the first drive line. Code 00 (normal) drives every line high. Code 01 drives only bit 5 high. Code 10 drives bits 4 and 5 high. Code 11 drives bits 1 to 5 high.
- R3: A scan starts only on the clock edge where the scanner is idle and some sense input reads 1. Each pass drives exactly one line high at a time, in order from bit 0 to bit 5. Each line is held for SCAN_TICKS/6 ticks.
- R4: The key seen on drive bit r and sense bit c sets key_data_o bit r*5+c. Several pressed keys set several bits.
- R5: When both passes hold the same non-zero result, key_data_o takes that result and key_req_o rises on the edge that processes tick REQ_TICKS of the scan, counted from the start edge. key_data_o changes at no other time except reset.
- R6: If the two passes differ and the second pass saw a key, the scan restarts from zero. A stable key is then reported 2*REQ_TICKS ticks after the first start.
- R7: If the two passes differ and the second pass saw nothing, the scanner returns to idle without a request and leaves key_data_o unchanged. A press shorter than one pass is therefore never reported.
- R8: If both passes hold an all-zero result, key_data_o is cleared to 0 and the scanner returns to idle with no request.
- R9: read_done_i while the request is high drops the request on the next edge and starts a new scan. The request otherwise stays high. read_done_i at any other time has no effect.
- R10: line_sel_i 00 keeps all six lines for keys. Code 01 hands over drive bit 0. Codes 10 and 11 hand over drive bits 0 and 1. A handed-over line is always driven 0, and its key bits (bits 0..4 for bit 0, bits 5..9 for bit 1) read 0.
- R11: osc_wake_o is 1 in normal mode. In sleep mode it is 1 while any sense input reads 1 or a scan or pending request is in progress, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base tick, one per oscillator period |
| sense_i | input | 5 | Sense lines, 1 for a pressed key on the driven line |
| sleep_code_i | input | 2 | Sleep code: 00 normal, else idle drive pattern in sleep |
| line_sel_i | input | 2 | Hands the lowest one or two drive lines to segment use |
| read_done_i | input | 1 | One-cycle pulse after the host has read the key data |
| drive_o | output | 6 | Drive line levels, bit 0 is the first line |
| key_data_o | output | 30 | Confirmed key bits |
| key_req_o | output | 1 | Read request to the host |
| osc_wake_o | output | 1 | Oscillator run/wake request |

## Verification
The assertions check the following on every cycle. At most one drive line is high inside a pass. A handed-over line stays low. A pending request always carries non-zero key data and holds until read-done, then drops. Key data moves only on a decision edge or at reset. Whether a result is accepted, retried or dropped depends on the exact tick on which the second pass diverges. The idle-pattern dependence of wake-up from sleep also needs stimulus. So the exact request latency of REQ_TICKS or 2*REQ_TICKS ticks, the short-press rejection and the reduced-matrix results are shown only by the bench's scenarios with its matrix model.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

    localparam int KS_LINES = 6;
    localparam int KS_SENSE = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WAIT = 2'd2
    } scan_state_e;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,
        PH_SECOND = 2'd1,
        PH_GAP    = 2'd2
    } scan_phase_e;

    typedef struct packed {
        logic        sample;
        logic        decide;
        scan_phase_e phase;
    } scan_strobe_t;

    // Lowest drive lines handed to segment use: bit 0 = first line, bit 1 = second.
    function automatic logic [1:0] taken_lines(input logic [1:0] sel);
        case (sel)
            2'b00:   return 2'b00;
            2'b01:   return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    // Idle level of a drive line for a given sleep code.
    function automatic logic idle_high(input logic [1:0] code, input int line, input int nlines);
        case (code)
            2'b00:   return 1'b1;
            2'b01:   return line == nlines - 1;
            2'b10:   return line >= nlines - 2;
            default: return line >= 1;
        endcase
    endfunction

endpackage

// File: rtl/kscan_timebase.sv
module kscan_timebase
    import kscan_pkg::*;
#(
    parameter int NUM_LINES  = KS_LINES,
    parameter int SCAN_TICKS = 384,
    parameter int REQ_TICKS  = 800,
    parameter int RW         = $clog2(NUM_LINES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_i,
    input  logic           restart_i,
    input  logic           tick_i,
    output scan_strobe_t   strobe_o,
    output logic [RW-1:0]  row_o
);

    localparam int SLOT = SCAN_TICKS / NUM_LINES;
    localparam int SW   = (SLOT > 1) ? $clog2(SLOT) : 1;
    localparam int TW   = $clog2(REQ_TICKS + 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(NUM_LINES - 1);
    localparam logic [TW-1:0] SESS_LAST = TW'(REQ_TICKS - 1);

    logic [SW-1:0] slot_q;
    logic [RW-1:0] row_q;
    logic [TW-1:0] sess_q;
    scan_phase_e   phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            slot_q  <= '0;
            row_q   <= '0;
            sess_q  <= '0;
            phase_q <= PH_FIRST;
        end else if (run_i && tick_i) begin
            sess_q <= sess_q + 1'b1;
            if (phase_q != PH_GAP) begin
                if (slot_q == SLOT_LAST) begin
                    slot_q <= '0;
                    if (row_q == ROW_LAST) begin
                        row_q   <= '0;
                        phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_GAP;
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    assign strobe_o.sample = run_i && tick_i && (phase_q != PH_GAP) && (slot_q == SLOT_LAST);
    assign strobe_o.decide = run_i && tick_i && (sess_q == SESS_LAST);
    assign strobe_o.phase  = phase_q;
    assign row_o           = row_q;

    // R5: a decision is only taken after both passes are complete
    assert_decide_after_passes_R5: assert property (@(posedge clk) disable iff (rst)
        strobe_o.decide |-> (phase_q == PH_GAP));

    // R5: the session counter never runs beyond the request delay while scanning
    assert_session_bound_R5: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (sess_q <= SESS_LAST));

    // R3: the row index stays within the drive lines
    assert_row_range_R3: assert property (@(posedge clk) disable iff (rst)
        row_q <= ROW_LAST);

endmodule

// File: rtl/kscan_capture.sv
module kscan_capture
    import kscan_pkg::*;
#(
    parameter int NUM_LINES = KS_LINES,
    parameter int NUM_SENSE = KS_SENSE,
    parameter int RW        = $clog2(NUM_LINES),
    parameter int KEYS      = NUM_LINES * NUM_SENSE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  scan_strobe_t         strobe_i,
    input  logic [RW-1:0]        row_i,
    input  logic [NUM_SENSE-1:0] sense_i,
    input  logic [NUM_LINES-1:0] taken_i,
    output logic [KEYS-1:0]      pass_a_o,
    output logic [KEYS-1:0]      pass_b_o
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_row
        logic [NUM_SENSE-1:0] a_q;
        logic [NUM_SENSE-1:0] b_q;
        logic [NUM_SENSE-1:0] seen;
        logic                 hit;

        assign seen = taken_i[g] ? '0 : sense_i;
        assign hit  = strobe_i.sample && (row_i == RW'(g));

        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                a_q <= '0;
                b_q <= '0;
            end else if (hit) begin
                if (strobe_i.phase == PH_FIRST) begin
                    a_q <= seen;
                end else if (strobe_i.phase == PH_SECOND) begin
                    b_q <= seen;
                end
            end
        end

        assign pass_a_o[g*NUM_SENSE +: NUM_SENSE] = a_q;
        assign pass_b_o[g*NUM_SENSE +: NUM_SENSE] = b_q;
    end

endmodule

// File: rtl/kscan_drive.sv
module kscan_drive
    import kscan_pkg::*;
#(
    parameter int NUM_LINES = KS_LINES,
    parameter int RW        = $clog2(NUM_LINES)
) (
    input  scan_state_e          state_i,
    input  scan_phase_e          phase_i,
    input  logic [RW-1:0]        row_i,
    input  logic [1:0]           sleep_code_i,
    input  logic [NUM_LINES-1:0] taken_i,
    output logic [NUM_LINES-1:0] drive_o
);

    logic [NUM_LINES-1:0] idle_lv;
    logic [NUM_LINES-1:0] pulse_lv;
    logic                 pulsing;

    assign pulsing = (state_i == ST_SCAN) && (phase_i != PH_GAP);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign idle_lv[g]  = idle_high(sleep_code_i, g, NUM_LINES);
        assign pulse_lv[g] = (row_i == RW'(g));
    end

    assign drive_o = (pulsing ? pulse_lv : idle_lv) & ~taken_i;

endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
    import kscan_pkg::*;
#(
    parameter int NUM_LINES  = KS_LINES,
    parameter int NUM_SENSE  = KS_SENSE,
    parameter int SCAN_TICKS = 384,
    parameter int REQ_TICKS  = 800
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick_i,
    input  logic [NUM_SENSE-1:0]           sense_i,
    input  logic [1:0]                     sleep_code_i,
    input  logic [1:0]                     line_sel_i,
    input  logic                           read_done_i,
    output logic [NUM_LINES-1:0]           drive_o,
    output logic [NUM_LINES*NUM_SENSE-1:0] key_data_o,
    output logic                           key_req_o,
    output logic                           osc_wake_o
);

    localparam int KEYS = NUM_LINES * NUM_SENSE;
    localparam int RW   = $clog2(NUM_LINES);

    scan_state_e          state_q;
    logic [KEYS-1:0]      key_q;
    logic [KEYS-1:0]      pass_a;
    logic [KEYS-1:0]      pass_b;
    logic [NUM_LINES-1:0] taken;
    scan_strobe_t         strobe;
    logic [RW-1:0]        row;
    logic                 any_sense;
    logic                 passes_agree;
    logic                 second_seen;
    logic                 restart;

    assign taken        = {{(NUM_LINES-2){1'b0}}, taken_lines(line_sel_i)};
    assign any_sense    = |sense_i;
    assign passes_agree = (pass_a == pass_b);
    assign second_seen  = |pass_b;

    always_comb begin
        case (state_q)
            ST_IDLE: restart = any_sense;
            ST_SCAN: restart = strobe.decide && !passes_agree && second_seen;
            ST_WAIT: restart = read_done_i;
            default: restart = 1'b0;
        endcase
    end

    kscan_timebase #(
        .NUM_LINES (NUM_LINES),
        .SCAN_TICKS(SCAN_TICKS),
        .REQ_TICKS (REQ_TICKS),
        .RW        (RW)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .run_i    (state_q == ST_SCAN),
        .restart_i(restart),
        .tick_i   (tick_i),
        .strobe_o (strobe),
        .row_o    (row)
    );

    kscan_capture #(
        .NUM_LINES(NUM_LINES),
        .NUM_SENSE(NUM_SENSE),
        .RW       (RW),
        .KEYS     (KEYS)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .clear_i (restart),
        .strobe_i(strobe),
        .row_i   (row),
        .sense_i (sense_i),
        .taken_i (taken),
        .pass_a_o(pass_a),
        .pass_b_o(pass_b)
    );

    kscan_drive #(
        .NUM_LINES(NUM_LINES),
        .RW       (RW)
    ) u_drive (
        .state_i     (state_q),
        .phase_i     (strobe.phase),
        .row_i       (row),
        .sleep_code_i(sleep_code_i),
        .taken_i     (taken),
        .drive_o     (drive_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            key_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (any_sense) state_q <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (strobe.decide) begin
                        if (passes_agree) begin
                            key_q   <= pass_b;
                            state_q <= second_seen ? ST_WAIT : ST_IDLE;
                        end else if (!second_seen) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (read_done_i) state_q <= ST_SCAN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign key_data_o = key_q;
    assign key_req_o  = (state_q == ST_WAIT);
    assign osc_wake_o = (sleep_code_i == 2'b00) || (state_q != ST_IDLE) || any_sense;

    // R1: the cycle after reset shows cleared data and no request
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (key_data_o == '0 && !key_req_o));

    // R3: inside a pass no two lines are driven at once
    assert_single_line_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && strobe.phase != PH_GAP) |-> $onehot0(drive_o));

    // R5: a pending request always carries at least one key
    assert_req_has_keys_R5: assert property (@(posedge clk) disable iff (rst)
        key_req_o |-> (|key_data_o));

    // R5: key data moves only on a decision edge
    assert_data_moves_on_decide_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(key_data_o)) |-> $past(strobe.decide));

    // R9: read-done drops the request on the next edge
    assert_read_drops_req_R9: assert property (@(posedge clk) disable iff (rst)
        (key_req_o && read_done_i) |=> !key_req_o);

    // R9: without read-done the request holds
    assert_req_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (key_req_o && !read_done_i) |=> key_req_o);

    // R10: a handed-over first line is never driven
    assert_taken_line_low_R10: assert property (@(posedge clk) disable iff (rst)
        (line_sel_i != 2'b00) |-> !drive_o[0]);

    // R11: a request is only raised after the oscillator was kept awake
    assert_wake_before_req_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(key_req_o) |-> $past(osc_wake_o));

endmodule

// File: tb/tb_key_matrix_scanner.sv
module tb_key_matrix_scanner;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic [4:0]  sense;
    logic [1:0]  sleep_code;
    logic [1:0]  line_sel;
    logic        read_done;
    logic [5:0]  drive;
    logic [29:0] key_data;
    logic        key_req;
    logic        osc_wake;
    logic [29:0] pressed;
    logic        rand_tick;
    int          n_checks = 0;
    int          n_fail   = 0;
    int          cyc      = 0;
    bit          done     = 0;

    always #5 clk = ~clk;

    key_matrix_scanner dut (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .sense_i     (sense),
        .sleep_code_i(sleep_code),
        .line_sel_i  (line_sel),
        .read_done_i (read_done),
        .drive_o     (drive),
        .key_data_o  (key_data),
        .key_req_o   (key_req),
        .osc_wake_o  (osc_wake)
    );

    // Key matrix model: a pressed key couples its drive line to its sense line.
    always_comb begin
        sense = '0;
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 5; c++)
                if (drive[r] && pressed[r*5+c]) sense[c] = 1'b1;
    end

    always @(negedge clk) tick <= rand_tick ? ($urandom_range(0, 3) != 0) : 1'b1;

    function automatic logic [5:0] exp_idle(input logic [1:0] sc, input logic [1:0] sl);
        logic [5:0] lv;
        case (sc)
            2'd0:    lv = 6'b111111;
            2'd1:    lv = 6'b100000;
            2'd2:    lv = 6'b110000;
            default: lv = 6'b111110;
        endcase
        if (sl == 2'd1) lv[0] = 1'b0;
        else if (sl != 2'd0) lv[1:0] = 2'b00;
        return lv;
    endfunction

    function automatic logic [29:0] exp_keymask(input logic [1:0] sl);
        logic [29:0] m = '1;
        if (sl == 2'd1) m[4:0] = '0;
        else if (sl != 2'd0) m[9:0] = '0;
        return m;
    endfunction

    function automatic bit exp_wakes(input logic [29:0] pk, input logic [1:0] sc, input logic [1:0] sl);
        logic [5:0] lv = exp_idle(sc, sl);
        for (int r = 0; r < 6; r++)
            for (int c = 0; c < 5; c++)
                if (lv[r] && pk[r*5+c]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_pulse();
        read_done = 1'b1;
        edges(1);
        read_done = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        edges(3);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; tick = 1'b1; rand_tick = 1'b0;
        sleep_code = 2'd0; line_sel = 2'd0; read_done = 1'b0; pressed = '0;
        do_reset();

        // R1 reset state
        check("R1 key data after reset", 32'(key_data), 32'h0);
        check("R1 request after reset", 32'(key_req), 32'h0);
        check("R1 drive after reset", 32'(drive), 32'h3F);
        check("R11 wake in normal mode", 32'(osc_wake), 32'h1);

        // R2 / R10 idle patterns, R11 sleep wake low with no keys
        for (int sc = 0; sc < 4; sc++) begin
            for (int sl = 0; sl < 4; sl++) begin
                sleep_code = 2'(sc); line_sel = 2'(sl);
                edges(2);
                check("R2 R10 idle drive pattern", 32'(drive), 32'(exp_idle(2'(sc), 2'(sl))));
                check("R11 wake idle", 32'(osc_wake), (sc == 0) ? 32'h1 : 32'h0);
                check("R3 no scan without keys", 32'(key_req), 32'h0);
            end
        end
        sleep_code = 2'd0; line_sel = 2'd0;
        edges(2);

        // R3 R4 R5 single key, exact timing (drive bit 2, sense bit 3 -> bit 13)
        pressed = 30'h1 << 13;
        edges(1);
        check("R3 first line driven at scan start", 32'(drive), 32'h01);
        edges(140);
        check("R3 third line driven in its slot", 32'(drive), 32'h04);
        edges(659);
        check("R5 no request before delay", 32'(key_req), 32'h0);
        edges(1);
        check("R5 request at delay", 32'(key_req), 32'h1);
        check("R4 key bit position", 32'(key_data), 32'h1 << 13);

        // R9 read clears, R8 release clears data
        read_pulse();
        check("R9 read drops request", 32'(key_req), 32'h0);
        pressed = '0;
        edges(810);
        check("R8 released matrix clears data", 32'(key_data), 32'h0);
        check("R8 no request when released", 32'(key_req), 32'h0);

        // R4 multiple keys, R9 held key re-reported after read
        pressed = (30'h1 << 0) | (30'h1 << 4) | (30'h1 << 28);
        edges(801);
        check("R4 multiple keys request", 32'(key_req), 32'h1);
        check("R4 multiple key bits", 32'(key_data), 32'h1000_0011);
        read_pulse();
        edges(801);
        check("R9 rescan after read reports held keys", 32'(key_req), 32'h1);
        read_pulse();
        pressed = '0;
        edges(810);

        // R7 short press during rescan keeps data, R9 read in idle ignored
        pressed = 30'h1;
        edges(801);
        check("R5 single key request", 32'(key_req), 32'h1);
        read_pulse();
        edges(300);
        pressed = '0;
        edges(600);
        check("R7 short press no request", 32'(key_req), 32'h0);
        check("R7 short press keeps data", 32'(key_data), 32'h1);
        read_pulse();
        check("R9 idle read keeps data", 32'(key_data), 32'h1);
        check("R9 idle read no request", 32'(key_req), 32'h0);
        check("R9 idle read drive idle", 32'(drive), 32'h3F);

        // R6 mismatch with key still seen -> retry, request at twice the delay
        pressed = 30'h1;
        edges(401);
        pressed = 30'h1 << 6;
        edges(1199);
        check("R6 no request after first session", 32'(key_req), 32'h0);
        edges(1);
        check("R6 request after retry", 32'(key_req), 32'h1);
        check("R6 retry key data", 32'(key_data), 32'h40);
        read_pulse();
        pressed = '0;
        edges(810);

        // R10 handed-over lines
        line_sel = 2'd2;
        edges(2);
        pressed = (30'h1 << 2) | (30'h1 << 12);
        edges(801);
        check("R10 two lines taken request", 32'(key_req), 32'h1);
        check("R10 two lines taken data", 32'(key_data), 32'h1 << 12);
        read_pulse();
        pressed = '0;
        edges(810);
        line_sel = 2'd1;
        edges(2);
        pressed = (30'h1 << 1) | (30'h1 << 7);
        edges(801);
        check("R10 one line taken data", 32'(key_data), 32'h1 << 7);
        read_pulse();
        pressed = '0;
        edges(810);
        line_sel = 2'd0;

        // R11 R3 sleep: key on a low idle line does not wake
        sleep_code = 2'd1;
        edges(2);
        pressed = 30'h1;
        edges(1);
        check("R11 no wake from low line", 32'(osc_wake), 32'h0);
        edges(900);
        check("R3 no scan from low line", 32'(key_req), 32'h0);
        pressed = 30'h1 | (30'h1 << 27);
        #1;
        check("R11 wake from high line", 32'(osc_wake), 32'h1);
        edges(801);
        check("R11 sleep scan request", 32'(key_req), 32'h1);
        check("R11 sleep scan sees all lines", 32'(key_data), 32'h0800_0001);
        read_pulse();
        pressed = '0;
        edges(810);
        check("R11 wake drops in idle sleep", 32'(osc_wake), 32'h0);
        sleep_code = 2'd0;

        // R1 reset while a request is pending
        pressed = 30'h1 << 20;
        edges(801);
        check("R5 request before reset", 32'(key_req), 32'h1);
        pressed = '0;
        do_reset();
        check("R1 reset clears pending data", 32'(key_data), 32'h0);
        check("R1 reset drops request", 32'(key_req), 32'h0);

        // Random modes, keys and tick gaps
        rand_tick = 1'b1;
        for (int it = 0; it < 12; it++) begin
            logic [1:0]  sc;
            logic [1:0]  sl;
            logic [29:0] pk;
            logic [29:0] expd;
            bit          go;
            sc = 2'($urandom_range(0, 3));
            sl = 2'($urandom_range(0, 3));
            pk = '0;
            pk[$urandom_range(0, 29)] = 1'b1;
            if ($urandom_range(0, 1) == 1) pk[$urandom_range(0, 29)] = 1'b1;
            sleep_code = sc; line_sel = sl;
            edges(2);
            go   = exp_wakes(pk, sc, sl);
            expd = pk & exp_keymask(sl);
            pressed = pk;
            for (int w = 0; w < 3500 && !key_req; w++) edges(1);
            if (go) begin
                check("R5 random request", 32'(key_req), 32'h1);
                check("R4 R10 random key data", 32'(key_data), 32'(expd));
            end else begin
                check("R3 random no scan", 32'(key_req), 32'h0);
                check("R3 random data untouched", 32'(key_data), 32'h0);
            end
            if (key_req) read_pulse();
            pressed = '0;
            edges(3500);
            check("R8 random release clears", 32'(key_data), 32'h0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 195000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule